// File: doc/BRIEF.md
# Counter-Based Variable Pulse Position Modulator

This block turns a one-bit data stream and a brightness setting into a single modulated light-drive bit for visible-light links. Each symbol is a fixed run of `NSAMP` samples. The brightness setting decides how many of those samples are lit. The data bit decides where the lit run sits. A 0 puts it at the front of the symbol and a 1 puts it at the back. The average light level therefore follows the brightness setting whatever data is sent.

No stored pattern per brightness step is kept. A sample index counter runs through each symbol. The index is compared against a transition point, which is the level for a 0 and `NSAMP` minus the level for a 1. The compare result is inverted for a 0 and passed as is for a 1. The logic grows only with the log of the step count.

A surrounding timing unit supplies a one-cycle strobe per sample. On the first sample of each symbol it also raises the symbol strobe. The data bit and the level are taken on that first sample and held until the next symbol starts.

Top module: `vppm_modulator`

## Requirements
- R1: While `rst_n` is low at a clock edge, `mod_out` is 0 after that edge.
- R2: A clock edge with `enable` low drives `mod_out` to 0. After `enable` returns high, `mod_out` stays 0 until a sample that also carries the symbol strobe.
- R3: With the captured data bit 0 and level L (0 < L < NSAMP), samples 0..L-1 of the symbol give `mod_out` = 1 and samples L..NSAMP-1 give 0.
- R4: With the captured data bit 1 and level L (0 < L < NSAMP), samples 0..NSAMP-L-1 give `mod_out` = 0 and the last L samples give 1.
- R5: Level 0 gives `mod_out` = 0 on every sample of the symbol, whatever the data bit.
- R6: Level NSAMP gives `mod_out` = 1 on every sample of the symbol, whatever the data bit.
- R7: A level input above NSAMP acts exactly as NSAMP.
- R8: Changes to `data_in` or `dim_level` on samples without the symbol strobe, or between strobes, do not change the current symbol's output.
- R9: `mod_out` changes only on the clock edge that takes a sample strobe, or on an edge with `enable` low or reset active.
- R10: The output for a sample is visible from the clock edge that takes that sample's strobe.
- R11: Samples beyond the NSAMP-th within one symbol repeat the value of the last sample (sample index NSAMP-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Modulator on; low forces the output low and clears the state |
| sample_stb | input | 1 | One-cycle strobe marking a sample |
| symbol_stb | input | 1 | Marks the first sample of a symbol; only used together with `sample_stb` |
| data_in | input | 1 | Data bit, taken on the first sample of a symbol |
| dim_level | input | LVL_W | Lit samples per symbol, taken on the first sample and clipped to NSAMP |
| mod_out | output | 1 | Registered modulated output |

## Verification
The checker assumes that `symbol_stb` carries meaning only in a cycle with `sample_stb` and `enable` high. Its checks of the first sample of a symbol look only at such cycles. It also assumes that `dim_level` is taken as an unsigned count, so any value above NSAMP is expected to light the full symbol. The stimulus changes inputs only at the falling clock edge. Between strobes it moves `data_in` and `dim_level` at random, so they differ from the captured pair. Symbols are normally exactly NSAMP samples long. A few directed symbols run past NSAMP, and one drops `enable` part way through a symbol.

// File: rtl/vppm_pkg.sv
// Shared definitions for the pulse position modulator.
// Assumes nothing beyond IEEE 1800-2017 synthesis support.
package vppm_pkg;

    // Where the lit run sits within a symbol, by data bit value.
    typedef enum logic {
        POS_LEADING  = 1'b0,
        POS_TRAILING = 1'b1
    } pulse_pos_e;

endpackage

// File: rtl/vppm_sample_counter.sv
// Sample index counter: gives the index of the sample being taken now.
// Restarts at 0 on a symbol strobe and saturates at NSAMP-1.
// Assumes restart is only honoured together with step.
module vppm_sample_counter #(
    parameter int NSAMP = 10,
    parameter int CNT_W = $clog2(NSAMP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             restart,
    output logic [CNT_W-1:0] idx_now
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NSAMP - 1);

    logic [CNT_W-1:0] cnt_q;

    // Index for the sample being taken this cycle.
    always_comb begin
        if (restart)
            idx_now = '0;
        else if (cnt_q == LAST_IDX)
            idx_now = cnt_q;
        else
            idx_now = cnt_q + 1'b1;
    end

    // Remember the index of the last sample taken.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (step)
            cnt_q <= idx_now;
    end
endmodule

// File: rtl/vppm_symbol_latch.sv
// Captures the data bit and the clipped level on the first sample of a symbol.
// The effective outputs bypass the register on the load cycle, so the
// first sample already uses the new values.
// Assumes load is only raised on a sample that starts a symbol.
module vppm_symbol_latch #(
    parameter int NSAMP = 10,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic             data_in,
    input  logic [LVL_W-1:0] level_raw,
    output logic             bit_eff,
    output logic [LVL_W-1:0] lvl_eff
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(NSAMP);

    logic [LVL_W-1:0] lvl_clip;
    logic             bit_q;
    logic [LVL_W-1:0] lvl_q;

    // Clip only when the level field can encode values above NSAMP.
    generate
        if ((2 ** LVL_W) - 1 > NSAMP) begin : g_clip
            always_comb lvl_clip = (level_raw > FULL_LVL) ? FULL_LVL : level_raw;
        end else begin : g_pass
            always_comb lvl_clip = level_raw;
        end
    endgenerate

    // Hold the symbol's bit and level until the next symbol starts.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            bit_q <= 1'b0;
            lvl_q <= '0;
        end else if (load) begin
            bit_q <= data_in;
            lvl_q <= lvl_clip;
        end
    end

    // Present the new values on the load cycle, the held ones otherwise.
    always_comb begin
        bit_eff = load ? data_in  : bit_q;
        lvl_eff = load ? lvl_clip : lvl_q;
    end
endmodule

// File: rtl/vppm_edge_select.sv
// Combinational output decision for one sample.
// The transition point is the level for a leading pulse and NSAMP minus the
// level for a trailing pulse. The index is compared with it (greater or
// equal), and the result is inverted for a leading pulse.
// Assumes lvl <= NSAMP and idx < NSAMP.
module vppm_edge_select
    import vppm_pkg::*;
#(
    parameter int NSAMP = 10,
    parameter int LVL_W = 4,
    parameter int CNT_W = $clog2(NSAMP)
) (
    input  logic             bit_in,
    input  logic [LVL_W-1:0] lvl,
    input  logic [CNT_W-1:0] idx,
    output logic             lit
);
    localparam int CMP_W = LVL_W + 1;

    pulse_pos_e       pos;
    logic [CMP_W-1:0] tpoint;
    logic [CMP_W-1:0] idx_x;
    logic             at_or_past;

    // Transition point, compare and polarity choice.
    always_comb begin
        pos        = pulse_pos_e'(bit_in);
        idx_x      = CMP_W'(idx);
        tpoint     = (pos == POS_TRAILING) ? (CMP_W'(NSAMP) - CMP_W'(lvl)) : CMP_W'(lvl);
        at_or_past = (idx_x >= tpoint);
        lit        = (pos == POS_TRAILING) ? at_or_past : ~at_or_past;
    end
endmodule

// File: rtl/vppm_modulator.sv
// Top level of the counter-based pulse position modulator.
// One registered output bit per sample strobe; enable low clears all state.
// Assumes symbol_stb is only meaningful with sample_stb high and that the
// strobes are single clk cycles.
module vppm_modulator #(
    parameter int NSAMP = 10,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sample_stb,
    input  logic             symbol_stb,
    input  logic             data_in,
    input  logic [LVL_W-1:0] dim_level,
    output logic             mod_out
);
    localparam int CNT_W = $clog2(NSAMP);

    logic             take;
    logic             start;
    logic             idle;
    logic [CNT_W-1:0] idx_now;
    logic             bit_eff;
    logic [LVL_W-1:0] lvl_eff;
    logic             lit;

    // Qualify the strobes with enable.
    always_comb begin
        idle  = ~enable;
        take  = enable & sample_stb;
        start = take & symbol_stb;
    end

    vppm_sample_counter #(
        .NSAMP (NSAMP),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (idle),
        .step    (take),
        .restart (start),
        .idx_now (idx_now)
    );

    vppm_symbol_latch #(
        .NSAMP (NSAMP),
        .LVL_W (LVL_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (idle),
        .load      (start),
        .data_in   (data_in),
        .level_raw (dim_level),
        .bit_eff   (bit_eff),
        .lvl_eff   (lvl_eff)
    );

    vppm_edge_select #(
        .NSAMP (NSAMP),
        .LVL_W (LVL_W),
        .CNT_W (CNT_W)
    ) u_edge (
        .bit_in (bit_eff),
        .lvl    (lvl_eff),
        .idx    (idx_now),
        .lit    (lit)
    );

    // Output register: updated on each taken sample, forced low when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || idle)
            mod_out <= 1'b0;
        else if (take)
            mod_out <= lit;
    end
endmodule

// File: rtl/vppm_modulator_chk.sv
// Port-level checker for vppm_modulator, attached by bind.
// Assumes symbol_stb is only acted on together with sample_stb and enable.
module vppm_modulator_chk #(
    parameter int NSAMP = 10,
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             sample_stb,
    input logic             symbol_stb,
    input logic             data_in,
    input logic [LVL_W-1:0] dim_level,
    input logic             mod_out
);
    logic first_smp;
    always_comb first_smp = enable && sample_stb && symbol_stb;

    // R1: reset drives the output low.
    p_reset_low_r1: assert property (@(posedge clk) !rst_n |=> !mod_out);

    // R2: enable low drives the output low.
    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !mod_out);

    // R9: no sample strobe, output holds.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        enable && !sample_stb |=> $stable(mod_out));

    // R3: leading pulse lights the first sample when the level is nonzero.
    p_lead_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        first_smp && !data_in && dim_level != '0 |=> mod_out);

    // R4: trailing pulse keeps the first sample dark below full level.
    p_trail_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        first_smp && data_in && dim_level < LVL_W'(NSAMP) |=> !mod_out);

    // R5: level 0 is dark from the first sample.
    p_zero_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        first_smp && dim_level == '0 |=> !mod_out);

    // R6 and R7: full or over-range level is lit from the first sample.
    p_full_lit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        first_smp && dim_level >= LVL_W'(NSAMP) |=> mod_out);
endmodule

bind vppm_modulator vppm_modulator_chk #(
    .NSAMP (NSAMP),
    .LVL_W (LVL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .sample_stb (sample_stb),
    .symbol_stb (symbol_stb),
    .data_in    (data_in),
    .dim_level  (dim_level),
    .mod_out    (mod_out)
);

// File: tb/tb_vppm_modulator.sv
`timescale 1ns/1ps
module tb_vppm_modulator;
    localparam int NSAMP = 10;
    localparam int LVL_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             sample_stb = 1'b0;
    logic             symbol_stb = 1'b0;
    logic             data_in = 1'b0;
    logic [LVL_W-1:0] dim_level = '0;
    logic             mod_out;

    int checks = 0;
    int fails  = 0;
    int seed_v;

    always #5 clk = ~clk;

    vppm_modulator #(.NSAMP(NSAMP), .LVL_W(LVL_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .sample_stb (sample_stb),
        .symbol_stb (symbol_stb),
        .data_in    (data_in),
        .dim_level  (dim_level),
        .mod_out    (mod_out)
    );

    // Expected output for a sample, from R3..R7 and R11.
    function automatic logic model(input logic b, input int raw, input int idx);
        int l = (raw > NSAMP) ? NSAMP : raw;
        int i = (idx > NSAMP - 1) ? NSAMP - 1 : idx;
        if (b) return (i >= NSAMP - l);
        return (i < l);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: mod_out=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Idle cycles between strobes; inputs are scrambled (R8) and output must hold (R9).
    task automatic gap(input int n, input logic exp);
        for (int g = 0; g < n; g++) begin
            @(negedge clk);
            sample_stb = 1'b0;
            symbol_stb = 1'b0;
            data_in    = 1'($urandom);
            dim_level  = LVL_W'($urandom);
            @(posedge clk); #1;
            check("R9", mod_out, exp);
        end
    endtask

    // One symbol of nsmp samples; R10: output checked just after the strobe edge.
    task automatic symbol(input logic b, input int raw, input int nsmp, input int maxgap, input string req);
        for (int s = 0; s < nsmp; s++) begin
            logic e;
            @(negedge clk);
            sample_stb = 1'b1;
            symbol_stb = (s == 0);
            data_in    = (s == 0) ? b : 1'($urandom);
            dim_level  = (s == 0) ? LVL_W'(raw) : LVL_W'($urandom);
            @(posedge clk); #1;
            e = model(b, raw, s);
            check(req, mod_out, e);
            gap((maxgap == 0) ? 0 : int'($urandom_range(maxgap)), e);
        end
    endtask

    initial begin
        seed_v = $urandom(32'h5EED_0123);
        // R1: reset state.
        repeat (3) @(posedge clk);
        #1 check("R1", mod_out, 1'b0);
        @(negedge clk);
        rst_n  = 1'b1;
        enable = 1'b1;

        // Directed corners.
        symbol(1'b0, 3, NSAMP, 1, "R3");
        symbol(1'b1, 3, NSAMP, 1, "R4");
        symbol(1'b0, 1, NSAMP, 0, "R3");
        symbol(1'b1, 9, NSAMP, 0, "R4");
        symbol(1'b0, 0, NSAMP, 1, "R5");
        symbol(1'b1, 0, NSAMP, 1, "R5");
        symbol(1'b0, NSAMP, NSAMP, 1, "R6");
        symbol(1'b1, NSAMP, NSAMP, 1, "R6");
        symbol(1'b0, 15, NSAMP, 1, "R7");
        symbol(1'b1, 12, NSAMP, 1, "R7");
        symbol(1'b0, 4, NSAMP + 3, 0, "R11");
        symbol(1'b1, 4, NSAMP + 3, 0, "R11");

        // R2: drop enable mid-symbol.
        symbol(1'b0, 8, 3, 0, "R3");
        @(negedge clk);
        enable = 1'b0;
        @(posedge clk); #1;
        check("R2", mod_out, 1'b0);
        @(negedge clk);
        enable = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            sample_stb = 1'b1;
            symbol_stb = 1'b0;
            data_in    = 1'b0;
            dim_level  = LVL_W'(NSAMP);
            @(posedge clk); #1;
            check("R2", mod_out, 1'b0);
        end
        @(negedge clk);
        sample_stb = 1'b0;
        symbol(1'b1, 6, NSAMP, 0, "R4");

        // Random symbols.
        for (int n = 0; n < 60; n++) begin
            logic b = 1'($urandom);
            int   r = int'($urandom_range(15));
            symbol(b, r, NSAMP, 2, b ? "R4" : "R3");
        end

        @(negedge clk);
        sample_stb = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule